// File: doc/BRIEF.md
# SDRAM Power-Down Sequencer

This block sits between a control register interface and the command pins of one or more SDRAM chip selects. It accepts either a raw 4-bit manual command code, or a high-level request to put a chip select into power-down or bring it back out. For a high-level request it plays out the ordered command sequence by itself. It precharges all banks, issues a NOP and moves the clock-enable line. The sequence differs between single-data-rate and double-data-rate parts. On a double-data-rate part it can also drop a DLL-enable output before entry.

Two guard functions work alongside the sequencer, one per chip select. A clock-stop control freezes or restarts that chip select's external memory clock after a programmable latency. A refresh guard counts the cycles a chip select spends with its clock-enable low. It raises a sticky error once that time passes a programmable refresh limit.

Top module: `sdram_pd_seq`

## Requirements
- R1: A manual command accepted while idle acts on chip select `man_cs` at the next clock edge. Code 4'b0001 puts a precharge-all on the command outputs (`cmd_valid`=1, `cmd_pre`=1) for one cycle. Code 4'b0000 puts a NOP there (`cmd_valid`=1, `cmd_pre`=0). Code 4'b1000 drives `cke` of that chip select low. Code 4'b0111 drives it high.
- R2: Any other manual code issues no command and leaves `cke` unchanged. It sets `illegal_cmd`, which then stays high until reset.
- R3: With `mode_ddr`=0, an entry request issues the following, one step per cycle: precharge-all, two cycles with no command, NOP, one final cycle with no command. After that cycle, `cke` of the requested chip select goes low.
- R4: With `mode_ddr`=1, an entry request issues precharge-all, then NOP, then one cycle with no command, then `cke` low. If `dll_off_en`=1, one extra leading cycle with no command comes first. `dll_en` is then low from the cycle in which the precharge-all appears.
- R5: An exit request spends one cycle with no command, then raises `cke` and `dll_en` together with a NOP. With `mode_ddr`=0, a precharge-all follows in the next cycle.
- R6: While `access_busy` is high, an accepted entry request waits. The block stays busy and issues no command. The sequence starts at the first edge that sees `access_busy` low.
- R7: `busy` is high from the edge that accepts a request until the sequence's last step completes. Any request seen while `busy` is high is dropped, and `req_reject` pulses in the next cycle. The same happens when several requests arrive in one idle cycle. Priority among them is entry, then exit, then manual.
- R8: A write to the clock-stop control with latency L changes `mclk_en` of that chip select L cycles after the edge that samples the write. With L=0, the change shows in the next cycle. Writing 1 stops the clock, and writing 0 restarts it.
- R9: While `cke` of a chip select stays low, its `refresh_err` bit rises `ref_limit`+1 edges after `cke` fell. The bit stays high until reset.
- R10: After reset, all `cke` bits, all `mclk_en` bits and `dll_en` are high. `busy`, `cmd_valid`, `req_reject`, `illegal_cmd` and `refresh_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_ddr | input | 1 | 1 selects the double-data-rate sequence |
| dll_off_en | input | 1 | Enables the DLL-off step on double-data-rate entry |
| access_busy | input | 1 | A memory access is pending or active |
| req_enter | input | 1 | Power-down entry request |
| req_exit | input | 1 | Power-down exit request |
| req_cs | input | CS_W | Chip select of the entry or exit request |
| man_valid | input | 1 | Manual command strobe |
| man_cs | input | CS_W | Chip select of the manual command |
| man_code | input | 4 | Manual command code |
| clkstop_wr | input | 1 | Clock-stop control write strobe |
| clkstop_cs | input | CS_W | Chip select of the clock-stop write |
| clkstop_val | input | 1 | 1 stops the clock, 0 restarts it |
| clk_lat | input | LAT_W | Clock-stop latency in cycles |
| ref_limit | input | REF_W | Refresh-period limit in cycles |
| cmd_valid | output | 1 | A command is on the command outputs |
| cmd_pre | output | 1 | 1 precharge-all, 0 NOP |
| cmd_cs | output | CS_W | Target chip select of the command |
| cke | output | NUM_CS | Clock-enable per chip select |
| mclk_en | output | NUM_CS | External memory clock run enable per chip select |
| dll_en | output | 1 | DLL enable |
| busy | output | 1 | Sequence in progress |
| req_reject | output | 1 | Pulse: a request was dropped |
| illegal_cmd | output | 1 | Sticky: an undefined manual code was seen |
| refresh_err | output | NUM_CS | Sticky: power-down exceeded the refresh limit |

## Verification
The assertions assume that `mode_ddr` and `dll_off_en` stay still while `busy` is high. They also assume that every chip-select index presented is below `NUM_CS`. The refresh-guard properties assume that `ref_limit` does not change while a chip select is powered down. The directed tests change configuration only between sequences, and they drive only indices 0 and 1. They set `ref_limit` once per scenario, and they pick a limit well beyond any sequence length except in the refresh scenario.

// File: rtl/pd_pkg.sv
package pd_pkg;

  typedef enum logic [2:0] {
    MC_NOP   = 3'd0,
    MC_PRE   = 3'd1,
    MC_CKELO = 3'd2,
    MC_CKEHI = 3'd3,
    MC_BAD   = 3'd4
  } man_kind_t;

  typedef enum logic [3:0] {
    S_IDLE, S_HOLD, S_DLL, S_EPRE, S_EW1, S_EW2, S_ENOP, S_ECKE,
    S_XCKE, S_XNOP, S_XPRE
  } seq_state_t;

  function automatic man_kind_t decode_code(input logic [3:0] code);
    case (code)
      4'b0000: return MC_NOP;
      4'b0001: return MC_PRE;
      4'b1000: return MC_CKELO;
      4'b0111: return MC_CKEHI;
      default: return MC_BAD;
    endcase
  endfunction

  // Fires on the edge where a pending clock-stop change takes effect.
  function automatic logic gate_due(input logic pend, input logic [15:0] cnt);
    return pend && (cnt == 16'd1);
  endfunction

  function automatic logic ref_expired(input logic cke_lvl,
                                       input logic [31:0] cnt,
                                       input logic [31:0] limit);
    return !cke_lvl && (cnt >= limit);
  endfunction

endpackage

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
  import pd_pkg::*;
#(
  parameter int CS_W = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_enter,
  input  logic            start_exit,
  input  logic [CS_W-1:0] cs_in,
  input  logic            mode_ddr,
  input  logic            dll_off_en,
  input  logic            access_busy,
  output logic            seq_busy,
  output logic            seq_hold,
  output logic            seq_cmd_v,
  output logic            seq_cmd_pre,
  output logic [CS_W-1:0] seq_cs,
  output logic            ev_cke_lo,
  output logic            ev_cke_hi,
  output logic            ev_dll_lo
);

  seq_state_t state, nxt;
  logic       ddr_q, dll_q;
  logic       first_ddr_dll;

  assign first_ddr_dll = mode_ddr && dll_off_en;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: begin
        if (start_enter) begin
          if (access_busy)        nxt = S_HOLD;
          else if (first_ddr_dll) nxt = S_DLL;
          else                    nxt = S_EPRE;
        end else if (start_exit) begin
          nxt = S_XCKE;
        end
      end
      S_HOLD:  if (!access_busy) nxt = (ddr_q && dll_q) ? S_DLL : S_EPRE;
      S_DLL:   nxt = S_EPRE;
      S_EPRE:  nxt = ddr_q ? S_ENOP : S_EW1;
      S_EW1:   nxt = S_EW2;
      S_EW2:   nxt = S_ENOP;
      S_ENOP:  nxt = S_ECKE;
      S_ECKE:  nxt = S_IDLE;
      S_XCKE:  nxt = S_XNOP;
      S_XNOP:  nxt = ddr_q ? S_IDLE : S_XPRE;
      S_XPRE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ddr_q  <= 1'b0;
      dll_q  <= 1'b0;
      seq_cs <= '0;
    end else begin
      state <= nxt;
      if (state == S_IDLE && (start_enter || start_exit)) begin
        ddr_q  <= mode_ddr;
        dll_q  <= dll_off_en;
        seq_cs <= cs_in;
      end
    end
  end

  assign seq_busy    = (state != S_IDLE);
  assign seq_hold    = (state == S_HOLD);
  assign seq_cmd_v   = (state == S_EPRE) || (state == S_ENOP) ||
                       (state == S_XNOP) || (state == S_XPRE);
  assign seq_cmd_pre = (state == S_EPRE) || (state == S_XPRE);
  assign ev_cke_lo   = (state == S_ECKE);
  assign ev_cke_hi   = (state == S_XCKE);
  assign ev_dll_lo   = (state == S_DLL);

endmodule

// File: rtl/pd_clk_gate.sv
module pd_clk_gate
  import pd_pkg::*;
#(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             stop_val,
  input  logic [LAT_W-1:0] lat,
  output logic             run
);

  logic [LAT_W-1:0] cnt;
  logic             pend, tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
      tgt  <= 1'b0;
      run  <= 1'b1;
    end else if (wr) begin
      tgt <= stop_val;
      if (lat == '0) begin
        run  <= !stop_val;
        pend <= 1'b0;
      end else begin
        cnt  <= lat;
        pend <= 1'b1;
      end
    end else if (pend) begin
      if (gate_due(pend, 16'(cnt))) begin
        run  <= !tgt;
        pend <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/pd_refresh_guard.sv
module pd_refresh_guard
  import pd_pkg::*;
#(
  parameter int REF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_lvl,
  input  logic [REF_W-1:0] limit,
  output logic             err
);

  logic [REF_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      err <= 1'b0;
    end else begin
      if (cke_lvl)        cnt <= '0;
      else if (cnt != '1) cnt <= cnt + 1'b1;
      if (ref_expired(cke_lvl, 32'(cnt), 32'(limit))) err <= 1'b1;
    end
  end

endmodule

// File: rtl/sdram_pd_seq.sv
module sdram_pd_seq
  import pd_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int LAT_W  = 4,
  parameter int REF_W  = 16,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ddr,
  input  logic              dll_off_en,
  input  logic              access_busy,
  input  logic              req_enter,
  input  logic              req_exit,
  input  logic [CS_W-1:0]   req_cs,
  input  logic              man_valid,
  input  logic [CS_W-1:0]   man_cs,
  input  logic [3:0]        man_code,
  input  logic              clkstop_wr,
  input  logic [CS_W-1:0]   clkstop_cs,
  input  logic              clkstop_val,
  input  logic [LAT_W-1:0]  clk_lat,
  input  logic [REF_W-1:0]  ref_limit,
  output logic              cmd_valid,
  output logic              cmd_pre,
  output logic [CS_W-1:0]   cmd_cs,
  output logic [NUM_CS-1:0] cke,
  output logic [NUM_CS-1:0] mclk_en,
  output logic              dll_en,
  output logic              busy,
  output logic              req_reject,
  output logic              illegal_cmd,
  output logic [NUM_CS-1:0] refresh_err
);

  // Named internal events, observed by the bound checker.
  logic            seq_busy, seq_hold, seq_cmd_v, seq_cmd_pre;
  logic [CS_W-1:0] seq_cs;
  logic            ev_cke_lo, ev_cke_hi, ev_dll_lo;
  logic            take_enter, take_exit, man_take, req_multi, any_req;
  logic [1:0]      n_req;
  man_kind_t       man_kind;
  logic [NUM_CS-1:0] cke_lo_ev, cke_hi_ev, cke_ev;

  logic            man_cmd_v_q, man_pre_q;
  logic [CS_W-1:0] man_cs_q;

  assign any_req    = req_enter || req_exit || man_valid;
  assign n_req      = 2'(req_enter) + 2'(req_exit) + 2'(man_valid);
  assign req_multi  = (n_req > 2'd1);
  assign take_enter = !seq_busy && req_enter;
  assign take_exit  = !seq_busy && req_exit && !req_enter;
  assign man_take   = !seq_busy && man_valid && !req_enter && !req_exit;
  assign man_kind   = decode_code(man_code);

  pd_seq_fsm #(.CS_W(CS_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_enter (take_enter),
    .start_exit  (take_exit),
    .cs_in       (req_cs),
    .mode_ddr    (mode_ddr),
    .dll_off_en  (dll_off_en),
    .access_busy (access_busy),
    .seq_busy    (seq_busy),
    .seq_hold    (seq_hold),
    .seq_cmd_v   (seq_cmd_v),
    .seq_cmd_pre (seq_cmd_pre),
    .seq_cs      (seq_cs),
    .ev_cke_lo   (ev_cke_lo),
    .ev_cke_hi   (ev_cke_hi),
    .ev_dll_lo   (ev_dll_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      man_cmd_v_q <= 1'b0;
      man_pre_q   <= 1'b0;
      man_cs_q    <= '0;
      illegal_cmd <= 1'b0;
      req_reject  <= 1'b0;
      dll_en      <= 1'b1;
    end else begin
      man_cmd_v_q <= man_take && (man_kind == MC_NOP || man_kind == MC_PRE);
      man_pre_q   <= (man_kind == MC_PRE);
      man_cs_q    <= man_cs;
      if (man_take && man_kind == MC_BAD) illegal_cmd <= 1'b1;
      req_reject  <= (seq_busy && any_req) || (!seq_busy && req_multi);
      if (ev_dll_lo)      dll_en <= 1'b0;
      else if (ev_cke_hi) dll_en <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cke_lo_ev[i] = (ev_cke_lo && seq_cs == CS_W'(i)) ||
                          (man_take && man_kind == MC_CKELO && man_cs == CS_W'(i));
    assign cke_hi_ev[i] = (ev_cke_hi && seq_cs == CS_W'(i)) ||
                          (man_take && man_kind == MC_CKEHI && man_cs == CS_W'(i));
    assign cke_ev[i]    = cke_lo_ev[i] || cke_hi_ev[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cke[i] <= 1'b1;
      else if (cke_lo_ev[i]) cke[i] <= 1'b0;
      else if (cke_hi_ev[i]) cke[i] <= 1'b1;
    end

    pd_clk_gate #(.LAT_W(LAT_W)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (clkstop_wr && clkstop_cs == CS_W'(i)),
      .stop_val (clkstop_val),
      .lat      (clk_lat),
      .run      (mclk_en[i])
    );

    pd_refresh_guard #(.REF_W(REF_W)) u_ref (
      .clk     (clk),
      .rst_n   (rst_n),
      .cke_lvl (cke[i]),
      .limit   (ref_limit),
      .err     (refresh_err[i])
    );
  end

  assign busy      = seq_busy;
  assign cmd_valid = seq_cmd_v || man_cmd_v_q;
  assign cmd_pre   = seq_cmd_v ? seq_cmd_pre : man_pre_q;
  assign cmd_cs    = seq_cmd_v ? seq_cs : man_cs_q;

endmodule

// File: rtl/pd_seq_checker.sv
module pd_seq_checker #(
  parameter int NUM_CS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              hold,
  input logic              cmd_valid,
  input logic              man_take,
  input logic              req_multi,
  input logic              req_reject,
  input logic              illegal_cmd,
  input logic              dll_en,
  input logic [NUM_CS-1:0] cke,
  input logic [NUM_CS-1:0] cke_ev,
  input logic [NUM_CS-1:0] refresh_err
);

  p_cke_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((cke ^ $past(cke)) & ~$past(cke_ev)) == '0));

  p_illegal_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_cmd |=> illegal_cmd);

  p_dll_drop_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dll_en) |-> busy);

  p_hold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !cmd_valid);

  p_cmd_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (busy || $past(man_take)));

  p_reject_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_reject |-> ($past(busy) || $past(req_multi)));

  p_referr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(refresh_err) & ~refresh_err) == '0));

  p_referr_cke_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((refresh_err & ~$past(refresh_err)) & $past(cke)) == '0));

endmodule

bind sdram_pd_seq pd_seq_checker #(.NUM_CS(NUM_CS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .hold        (seq_hold),
  .cmd_valid   (cmd_valid),
  .man_take    (man_take),
  .req_multi   (req_multi),
  .req_reject  (req_reject),
  .illegal_cmd (illegal_cmd),
  .dll_en      (dll_en),
  .cke         (cke),
  .cke_ev      (cke_ev),
  .refresh_err (refresh_err)
);

// File: tb/sim_sdram_pd_seq.sv
module sim_sdram_pd_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_ddr = 0, dll_off_en = 0, access_busy = 0;
  logic       req_enter = 0, req_exit = 0, man_valid = 0;
  logic       req_cs = 0, man_cs = 0, clkstop_cs = 0, clkstop_wr = 0, clkstop_val = 0;
  logic [3:0] man_code = 0, clk_lat = 0;
  logic [15:0] ref_limit = 16'd1000;
  logic       cmd_valid, cmd_pre, cmd_cs, dll_en, busy, req_reject, illegal_cmd;
  logic [1:0] cke, mclk_en, refresh_err;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdram_pd_seq u0 (
    .clk(clk), .rst_n(rst_n), .mode_ddr(mode_ddr), .dll_off_en(dll_off_en),
    .access_busy(access_busy), .req_enter(req_enter), .req_exit(req_exit),
    .req_cs(req_cs), .man_valid(man_valid), .man_cs(man_cs), .man_code(man_code),
    .clkstop_wr(clkstop_wr), .clkstop_cs(clkstop_cs), .clkstop_val(clkstop_val),
    .clk_lat(clk_lat), .ref_limit(ref_limit), .cmd_valid(cmd_valid),
    .cmd_pre(cmd_pre), .cmd_cs(cmd_cs), .cke(cke), .mclk_en(mclk_en),
    .dll_en(dll_en), .busy(busy), .req_reject(req_reject),
    .illegal_cmd(illegal_cmd), .refresh_err(refresh_err)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  // Command bus as one value: {valid, pre, cs}
  function automatic logic [2:0] bus(); return {cmd_valid, cmd_pre, cmd_cs}; endfunction
  function automatic logic [2:0] c_pre(input logic cs); return {2'b11, cs}; endfunction
  function automatic logic [2:0] c_nop(input logic cs); return {2'b10, cs}; endfunction

  task automatic manual(input logic cs, input logic [3:0] code);
    man_valid = 1; man_cs = cs; man_code = code;
    tick();
    man_valid = 0;
  endtask

  task automatic t_reset();
    check("R10", "cke", cke, 2'b11);
    check("R10", "mclk_en", mclk_en, 2'b11);
    check("R10", "dll_en", dll_en, 1);
    check("R10", "busy/cmd", {busy, cmd_valid, req_reject}, 0);
    check("R10", "status", {illegal_cmd, refresh_err}, 0);
  endtask

  task automatic t_manual();
    manual(1, 4'b0001); check("R1", "precharge cs1", bus(), c_pre(1));
    manual(0, 4'b0000); check("R1", "nop cs0", bus(), c_nop(0));
    check("R1", "no pulse stretch", cmd_valid, 1);
    tick();             check("R1", "single cycle", cmd_valid, 0);
    manual(0, 4'b1000); check("R1", "cke low cs0", cke, 2'b10);
    manual(0, 4'b0111); check("R1", "cke high cs0", cke, 2'b11);
  endtask

  task automatic t_illegal();
    manual(1, 4'b1000); // cs1 low, then an undefined code must not touch it
    manual(1, 4'b0101);
    check("R2", "no command", cmd_valid, 0);
    check("R2", "cke unchanged", cke, 2'b01);
    check("R2", "illegal set", illegal_cmd, 1);
    manual(1, 4'b0111);
    tick(); check("R2", "illegal sticky", illegal_cmd, 1);
  endtask

  task automatic t_sdr_enter();
    mode_ddr = 0; req_cs = 1; req_enter = 1;
    tick(); req_enter = 0;
    check("R3", "pre", bus(), c_pre(1)); check("R7", "busy", busy, 1);
    tick(); check("R3", "wait1", cmd_valid, 0);
    tick(); check("R3", "wait2", cmd_valid, 0);
    tick(); check("R3", "nop", bus(), c_nop(1));
    tick(); check("R3", "cke still high", {cmd_valid, cke[1], busy}, 3'b011);
    tick(); check("R3", "cke low", cke, 2'b01); check("R7", "busy done", busy, 0);
  endtask

  task automatic t_exit(input logic ddr);
    mode_ddr = ddr; req_cs = 1; req_exit = 1;
    tick(); req_exit = 0;
    check("R5", "quiet step", {cmd_valid, cke[1]}, 2'b00);
    tick(); check("R5", "nop", bus(), c_nop(1));
    check("R5", "cke/dll high", {cke[1], dll_en}, 2'b11);
    tick();
    if (!ddr) begin
      check("R5", "sdr pre", bus(), c_pre(1));
      tick();
    end
    check("R5", "done", {busy, cmd_valid}, 0);
  endtask

  task automatic t_ddr_enter(input logic dll);
    mode_ddr = 1; dll_off_en = dll; req_cs = 1; req_enter = 1;
    tick(); req_enter = 0;
    if (dll) begin
      check("R4", "dll step quiet", {cmd_valid, dll_en}, 2'b01);
      tick();
    end
    check("R4", "pre", bus(), c_pre(1));
    check("R4", "dll_en", dll_en, !dll);
    tick(); check("R4", "nop", bus(), c_nop(1));
    tick(); check("R4", "last step", {cmd_valid, cke[1], busy}, 3'b011);
    tick(); check("R4", "cke low", {cke, busy}, 3'b010);
    dll_off_en = 0;
  endtask

  task automatic t_hold();
    mode_ddr = 1; access_busy = 1; req_cs = 0; req_enter = 1;
    tick(); req_enter = 0;
    for (int k = 0; k < 3; k++) begin
      check("R6", "held", {busy, cmd_valid}, 2'b10);
      tick();
    end
    access_busy = 0;
    tick(); check("R6", "start pre", bus(), c_pre(0));
    tick(); tick(); tick();
    check("R6", "cke0 low", cke[0], 0);
    req_cs = 0; req_exit = 1; tick(); req_exit = 0; tick(); tick();
  endtask

  task automatic t_reject();
    mode_ddr = 0; req_cs = 0; req_enter = 1;
    tick(); req_enter = 0;
    man_valid = 1; man_cs = 0; man_code = 4'b1000;
    tick(); man_valid = 0;
    check("R7", "reject pulse", req_reject, 1);
    check("R7", "busy manual dropped", cke[0], 1);
    tick(); check("R7", "pulse ends", req_reject, 0);
    for (int k = 0; k < 4; k++) tick();
    check("R7", "seq finishes", {busy, cke[0]}, 2'b00);
    req_exit = 1; man_valid = 1; man_code = 4'b0001;
    tick(); req_exit = 0; man_valid = 0;
    check("R7", "collision rejected", req_reject, 1);
    check("R7", "exit wins", {cmd_valid, busy}, 2'b01);
    tick(); tick(); tick();
    check("R7", "exit done", {busy, cke[0]}, 2'b01);
  endtask

  task automatic t_clkgate();
    clkstop_wr = 1; clkstop_cs = 0; clkstop_val = 1; clk_lat = 4'd3;
    tick(); clkstop_wr = 0;
    tick(); tick();
    check("R8", "not yet", mclk_en, 2'b11);
    tick(); check("R8", "stopped after 3", mclk_en, 2'b10);
    clkstop_wr = 1; clkstop_val = 0; clk_lat = 4'd0;
    tick(); clkstop_wr = 0;
    check("R8", "restart latency 0", mclk_en, 2'b11);
  endtask

  task automatic t_refresh();
    ref_limit = 16'd5;
    manual(1, 4'b1000);
    for (int k = 0; k < 5; k++) tick();
    check("R9", "not expired", refresh_err, 0);
    tick(); check("R9", "expired", refresh_err, 2'b10);
    manual(1, 4'b0111);
    tick(); check("R9", "sticky", refresh_err, 2'b10);
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rst_n = 1;
    tick();
    t_manual();
    t_illegal();
    t_sdr_enter();
    t_exit(0);
    t_ddr_enter(0);
    t_exit(1);
    t_ddr_enter(1);
    t_exit(1);
    t_hold();
    t_reject();
    t_clkgate();
    t_refresh();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule